// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns a single-cycle write request on a clocked interface into a correctly ordered write cycle on an external 8192 x 8 asynchronous static RAM. It latches the 13-bit address and 8-bit data when it accepts a request. It then drives the memory's active-low chip select, its active-high second chip select and its active-low write strobe. It also controls the enable of its own data-bus drivers, with every interval counted in clock cycles.

Each request picks one of two strobe styles. In the write-strobed style, both chip selects go active first and the write line forms the strobe. In the select-strobed style, the write line goes low first and the two chip selects form the strobe. The caller can report that the memory's output enable is tied low. In the write-strobed style the block then stretches the strobe by a turn-off delay, and it keeps its drivers off until the memory's outputs have released the bus.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset and whenever not busy, mem_ce_n=1, mem_ce2=0, mem_we_n=1, mem_dq_oe=0, busy=0, done=0.
- R2: A memory write, meaning the overlap of mem_ce_n=0, mem_ce2=1 and mem_we_n=0, happens exactly once per accepted request. At the end of that overlap the driven data equals the request's wdata and mem_addr equals its addr.
- R3: mem_addr does not change while busy, and so never during a write overlap.
- R4: With wr_mode=0 (write-strobed), both chip selects are active for T_AS cycles with mem_we_n high before mem_we_n falls. mem_we_n then stays low for T_WP cycles, or for T_OFF+T_WP cycles when oe_low=1.
- R5: With wr_mode=1 (select-strobed), mem_we_n is low for T_AS cycles with the chip selects inactive before both chip selects become active. The chip selects then stay active for T_WP cycles.
- R6: mem_dq_oe is high for at least the last T_WP cycles of the write overlap. It stays high for exactly T_DH cycles after the overlap ends, and it is low during recovery.
- R7: With wr_mode=0 and oe_low=1, mem_dq_oe stays low until T_OFF cycles after mem_we_n falls, so it never overlaps a period in which the memory could drive the bus.
- R8: busy stays high for exactly T_AS + strobe length + T_DH + T_WR cycles. done is high for one cycle, which is the last busy cycle.
- R9: A req raised while busy is ignored and causes no further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Write request, sampled when idle |
| wr_mode | input | 1 | 0: write-strobed, 1: select-strobed (latched with req) |
| oe_low | input | 1 | Memory output enable is held low (latched with req) |
| addr | input | 13 | Write address |
| wdata | input | 8 | Write data |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle pulse on the last busy cycle |
| mem_addr | output | 13 | Memory address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 8 | Data toward the memory bus |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
A wrong phase state or a wrong counter load becomes visible at the ports within one write cycle. The strobe pulse has the wrong length, a second or missing write overlap shows in the bench's memory model, or busy and done do not land on the arithmetic cycle count. An early driver enable in the output-enabled case appears as contention in the same cycle it occurs, because the bench tracks when the memory's outputs could still be active. A stray acceptance of a request during busy appears as an extra committed write or a moved address before the current transaction ends.

// File: rtl/sram_wr_seq.sv
module sram_wr_seq #(
  parameter int AW    = 13,
  parameter int DW    = 8,
  parameter int T_AS  = 2,
  parameter int T_WP  = 3,
  parameter int T_DH  = 1,
  parameter int T_WR  = 2,
  parameter int T_OFF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr_mode,
  input  logic          oe_low,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);

  localparam int CW = $clog2(T_AS + T_WP + T_DH + T_WR + T_OFF + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD, S_RECOV} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          mode_q, oel_q;
  logic [CW-1:0] strb_len;
  logic          last, ce_act, we_act;

  assign strb_len = (!mode_q && oel_q) ? CW'(T_OFF + T_WP - 1) : CW'(T_WP - 1);
  assign last     = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
      oel_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st     <= S_SETUP;
          cnt    <= CW'(T_AS - 1);
          addr_q <= addr;
          data_q <= wdata;
          mode_q <= wr_mode;
          oel_q  <= oe_low;
        end
        S_SETUP: if (last) begin st <= S_STRB;  cnt <= strb_len;       end else cnt <= cnt - 1'b1;
        S_STRB:  if (last) begin st <= S_HOLD;  cnt <= CW'(T_DH - 1);  end else cnt <= cnt - 1'b1;
        S_HOLD:  if (last) begin st <= S_RECOV; cnt <= CW'(T_WR - 1);  end else cnt <= cnt - 1'b1;
        S_RECOV: if (last) st <= S_IDLE; else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ce_act     = (st == S_STRB) || (st == S_SETUP && !mode_q);
  assign we_act     = (st == S_STRB) || (st == S_SETUP &&  mode_q);
  assign mem_ce_n   = !ce_act;
  assign mem_ce2    = ce_act;
  assign mem_we_n   = !we_act;
  assign mem_addr   = addr_q;
  assign mem_dq_out = data_q;
  assign mem_dq_oe  = (st == S_HOLD) || (st == S_STRB && cnt < CW'(T_WP));
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_RECOV) && last;

endmodule

// File: rtl/sram_wr_seq_sva.sv
module sram_wr_seq_sva #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_ce2,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);
  logic wr_act;
  assign wr_act = !mem_ce_n && mem_ce2 && !mem_we_n;

  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && !mem_ce2 && mem_we_n && !mem_dq_oe && !done));

  p_write_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |-> busy);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));

  p_hold_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_act) |-> mem_dq_oe);

  p_drive_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && !mem_dq_oe) |=> !$fell(wr_act));

  p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
endmodule

bind sram_wr_seq sram_wr_seq_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_wr_seq.sv
module tb_sram_wr_seq;
  localparam int T_AS = 2, T_WP = 3, T_DH = 1, T_WR = 2, T_OFF = 2;

  logic        clk = 0, rst_n = 0, req = 0, wr_mode = 0, oe_low = 0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, done, mem_ce_n, mem_ce2, mem_we_n, mem_dq_oe;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dq_out;

  int checks = 0, errors = 0, commits = 0;
  bit finished = 0;
  logic [7:0] model [int];

  always #10 clk = ~clk;

  sram_wr_seq #(.T_AS(T_AS), .T_WP(T_WP), .T_DH(T_DH), .T_WR(T_WR), .T_OFF(T_OFF)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_mode(wr_mode), .oe_low(oe_low),
    .addr(addr), .wdata(wdata), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input bit m, input bit oel, input logic [12:0] a, input logic [7:0] d);
    int pre = 0, act_n = 0, oe_in_act = 0, hold = 0, busy_n = 0, done_n = 0, done_at = -1;
    int off_cnt = 0, contention = 0, addr_moves = 0, oe_recov = 0, cyc = 0, oe_run = 0, oe_tail = 0;
    int c0 = commits;
    bit seen = 0, prev_act = 0, mem_drv;
    logic [12:0] last_a = 'x;
    logic [7:0]  last_d = 'x;
    int slen = (!m && oel) ? T_OFF + T_WP : T_WP;
    @(negedge clk);
    req = 1; wr_mode = m; oe_low = oel; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    while (busy && cyc < 100) begin
      bit ce_on = !mem_ce_n && mem_ce2;
      bit wa = ce_on && !mem_we_n;
      cyc++;
      busy_n++;
      if (done) begin done_n++; done_at = busy_n; end
      if (!seen && !wa) begin
        if (!m && ce_on && mem_we_n) pre++;
        if (m && !mem_we_n && !ce_on) pre++;
      end
      mem_drv = (ce_on && mem_we_n && oel) || off_cnt > 0;
      if (mem_dq_oe && mem_drv) contention++;
      if (ce_on && mem_we_n && oel) off_cnt = T_OFF; else if (off_cnt > 0) off_cnt--;
      if (wa) begin
        seen = 1; act_n++;
        if (mem_dq_oe) begin oe_in_act++; oe_run++; end else oe_run = 0;
        if (last_a !== 'x && last_a !== mem_addr) addr_moves++;
        last_a = mem_addr;
        last_d = mem_dq_oe ? mem_dq_out : 'x;
      end else if (seen && mem_dq_oe) hold++;
      if (seen && !wa && !mem_dq_oe) oe_recov++;
      if (prev_act && !wa) begin model[int'(last_a)] = last_d; commits++; oe_tail = oe_run; end
      prev_act = wa;
      if (cyc == 2) begin req = 1; addr = a ^ 13'h1000; wdata = ~d; end
      if (cyc == 3) req = 0;
      @(negedge clk);
    end
    if (m == 0) chk(pre == T_AS, "R4 select-before-strobe cycles", pre, T_AS);
    else        chk(pre == T_AS, "R5 write-low-before-select cycles", pre, T_AS);
    chk(act_n == slen, m ? "R5 strobe length" : "R4 strobe length", act_n, slen);
    chk(commits - c0 == 1, "R2/R9 writes per request", commits - c0, 1);
    chk(model.exists(int'(a)) && model[int'(a)] === d, "R2 committed data",
        model.exists(int'(a)) ? int'(model[int'(a)]) : -1, int'(d));
    chk(last_a === a, "R2 committed address", int'(last_a), int'(a));
    chk(addr_moves == 0 && mem_addr === a, "R3 address stable", addr_moves, 0);
    chk(oe_tail >= T_WP, "R6 data setup cycles", oe_tail, T_WP);
    chk(hold == T_DH, "R6 data hold cycles", hold, T_DH);
    chk(contention == 0, "R7 bus contention cycles", contention, 0);
    chk(busy_n == T_AS + slen + T_DH + T_WR, "R8 busy length", busy_n, T_AS + slen + T_DH + T_WR);
    chk(done_n == 1 && done_at == busy_n, "R8 done position", done_at, busy_n);
    chk(!busy && !done && mem_ce_n && !mem_ce2 && mem_we_n && !mem_dq_oe, "R1 idle levels after write", 0, 0);
    if (oe_recov != T_WR) chk(0, "R6 driver off in recovery", oe_recov, T_WR);
  endtask

  initial begin
    #5;
    chk(mem_ce_n && !mem_ce2 && mem_we_n && !mem_dq_oe && !busy && !done, "R1 reset levels", 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce_n && !mem_ce2 && mem_we_n && !mem_dq_oe && !busy && !done, "R1 idle after reset", 0, 0);
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 2; o++)
        for (int i = 0; i < 6; i++) begin
          logic [12:0] a = (i == 0) ? 13'h0000 : (i == 1) ? 13'h1FFF : 13'((i * 1237 + m * 97 + o * 11) & 13'h0FFF);
          logic [7:0]  d = 8'((i * 37 + m * 101 + o * 53 + 5) & 8'hFF);
          do_write(m[0], o[0], a, d);
          repeat (2) @(negedge clk);
        end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule